// File: doc/BRIEF.md
# Central Interrupt Control Unit

This block owns the central interrupt control register of a small CPU core and decides, cycle by cycle, whether an interrupt is presented to the instruction sequencer. There are two request paths. The top-level path is driven by a pending flag that a trigger event or a software write raises. The maskable path arbitrates a vector of requests, each of which carries a 3-bit priority. The CPU drives plain strobes for enable, disable, acknowledge and return. The block answers with a top-level request, a maskable request and the index of the winning maskable source.

Arbitration runs in one of two modes. In concurrent mode the current priority level belongs to software alone. In nested mode a maskable acknowledge saves the old level on an internal stack and raises the level to that of the winner, and a return restores it. The top-level path can bypass the global enable when an external non-maskable enable allows it. While a top-level service is open, no new request of either kind is presented. All pins are plain control and status signals. There is no data stream, so no valid/ready handshake is involved.

Top module: `irq_central_ctl`

## Requirements
- R1: After reset the register reads 0x87. Bit 7 reads 1 at all times, whatever value is written to it.
- R2: Bit 6 (pending) is set by `top_trig`, cleared by a top-level acknowledge, and loaded with bit 6 of a register write. When a trigger and an acknowledge fall in the same cycle, the flag stays set. The flag is visible in the cycle after the edge.
- R3: `top_irq` is high when pending is 1, no top-level service is open, and either bit 5 is 0 and `nmi_en` is 1, or bit 5 is 1 and bit 4 is 1.
- R4: Bit 4 (enable) responds to events in this priority order: a maskable acknowledge clears it, then `cpu_di` clears it, then `cpu_ei` sets it, then a return not from top-level service sets it, then a register write loads it. A top-level acknowledge and a return from top-level service leave it unchanged.
- R5: A register write in a cycle where `top_irq` or `mask_irq` is high updates bits 6..0 except bit 4 at once. Its bit 4 takes effect one cycle later, below every other event of that cycle.
- R6: Bit 3 selects the mode: 0 is concurrent, 1 is nested. In concurrent mode, bits 2:0 (the level) change only by a register write.
- R7: In nested mode a maskable acknowledge pushes the old level onto an 8-entry stack and loads the winner's priority. A return not from top-level service pops the stack into the level. A pop with an empty stack leaves the level unchanged.
- R8: `mask_irq` is high when enable is 1, some valid request has a priority numerically below the level, `top_irq` is low and no top-level service is open.
- R9: `win_idx` names the valid request with the lowest priority number below the level. Ties go to the lowest index. It reads 0 when no request qualifies.
- R10: A `cpu_ack` while neither request is high changes nothing. A top-level acknowledge opens a top-level service, which the next `cpu_ret` closes. A `cpu_ret` in the same cycle as `cpu_ack` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Current register value |
| top_trig | input | 1 | Top-level trigger event, one cycle per event |
| nmi_en | input | 1 | Non-maskable enable from the neighbouring register |
| req_valid | input | NSRC | Maskable request lines |
| req_prio | input | 3*NSRC | Priority of each request, source i at bits 3i+2..3i |
| cpu_ei | input | 1 | Enable-interrupts strobe |
| cpu_di | input | 1 | Disable-interrupts strobe |
| cpu_ack | input | 1 | Interrupt acknowledge strobe |
| cpu_ret | input | 1 | Return-from-interrupt strobe |
| top_irq | output | 1 | Top-level interrupt request |
| mask_irq | output | 1 | Maskable interrupt request |
| win_idx | output | $clog2(NSRC) | Index of the winning maskable source |

## Verification
The three request outputs are combinational. They are due in the same cycle as any change on `req_valid`, `req_prio` or `nmi_en`, and in the cycle after a register change. Register effects of writes, strobes and triggers appear in the cycle after the sampling edge. The one exception is a deferred enable write, which appears two cycles after its edge. The bench drives inputs just after a rising edge and checks its own model against every output at the falling edge of each cycle. Its directed checks sample after the inputs have settled, in the cycle the requirement names.

// File: rtl/irq_central_pkg.sv
package irq_central_pkg;
  localparam int PRIO_W = 3;
  localparam logic [7:0] CTL_RESET = 8'h87;

  typedef struct packed {
    logic             pend;
    logic             tmode;
    logic             gen;
    logic             nest;
    logic [PRIO_W-1:0] lvl;
  } ctl_t;
endpackage

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int NSRC = 8,
  parameter int PW = 3,
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]    valid,
  input  logic [NSRC*PW-1:0] prio,
  input  logic [PW-1:0]      lvl,
  output logic               any,
  output logic [IW-1:0]      idx,
  output logic [PW-1:0]      win_prio
);
  logic [NSRC-1:0] qual;

  for (genvar i = 0; i < NSRC; i++) begin : g_qual
    assign qual[i] = valid[i] && (prio[i*PW +: PW] < lvl);
  end

  always_comb begin
    any      = 1'b0;
    idx      = '0;
    win_prio = '1;
    for (int i = 0; i < NSRC; i++) begin
      if (qual[i] && (!any || (prio[i*PW +: PW] < win_prio))) begin
        any      = 1'b1;
        idx      = IW'(i);
        win_prio = prio[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack #(
  parameter int DEPTH = 8,
  parameter int W = 3,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] cnt;
  logic [IW-1:0] top_i;
  logic          full;

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign top_i = empty ? '0 : IW'(cnt - 1'b1);
  assign dout  = mem[top_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (push && !full) begin
      cnt <= cnt + 1'b1;
    end else if (pop && !empty) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) begin
      mem[IW'(cnt)] <= din;
    end
  end
endmodule

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
  import irq_central_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [7:0]        wdata,
  input  logic              trig,
  input  logic              ei,
  input  logic              di,
  input  logic              ack_top,
  input  logic              ack_mask,
  input  logic              ret_top,
  input  logic              ret_mask,
  input  logic              busy,
  input  logic [PRIO_W-1:0] win_prio,
  input  logic              pop_ok,
  input  logic [PRIO_W-1:0] pop_lvl,
  output ctl_t              st,
  output logic              in_top
);
  ctl_t st_n;
  logic def_vld, def_vld_n, def_val, def_val_n, in_top_n;
  logic unused_wbit;

  assign unused_wbit = wdata[7];

  always_comb begin
    st_n      = st;
    def_vld_n = 1'b0;
    def_val_n = def_val;
    if (def_vld) st_n.gen = def_val;
    if (wr) begin
      st_n.pend  = wdata[6];
      st_n.tmode = wdata[5];
      st_n.nest  = wdata[3];
      st_n.lvl   = wdata[PRIO_W-1:0];
      if (busy) begin
        def_vld_n = 1'b1;
        def_val_n = wdata[4];
      end else begin
        st_n.gen = wdata[4];
      end
    end
    if (ret_mask) begin
      st_n.gen = 1'b1;
      if (pop_ok) st_n.lvl = pop_lvl;
    end
    if (ei) st_n.gen = 1'b1;
    if (di) st_n.gen = 1'b0;
    if (ack_mask) begin
      st_n.gen = 1'b0;
      if (st.nest) st_n.lvl = win_prio;
    end
    if (ack_top) st_n.pend = 1'b0;
    if (trig)    st_n.pend = 1'b1;
    in_top_n = in_top;
    if (ret_top) in_top_n = 1'b0;
    if (ack_top) in_top_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ctl_t'(CTL_RESET[6:0]);
      def_vld <= 1'b0;
      def_val <= 1'b0;
      in_top  <= 1'b0;
    end else begin
      st      <= st_n;
      def_vld <= def_vld_n;
      def_val <= def_val_n;
      in_top  <= in_top_n;
    end
  end
endmodule

// File: rtl/irq_central_ctl.sv
module irq_central_ctl
  import irq_central_pkg::*;
#(
  parameter int NSRC = 8,
  parameter int STACK_DEPTH = 8,
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   reg_wr,
  input  logic [7:0]             reg_wdata,
  output logic [7:0]             reg_rdata,
  input  logic                   top_trig,
  input  logic                   nmi_en,
  input  logic [NSRC-1:0]        req_valid,
  input  logic [NSRC*PRIO_W-1:0] req_prio,
  input  logic                   cpu_ei,
  input  logic                   cpu_di,
  input  logic                   cpu_ack,
  input  logic                   cpu_ret,
  output logic                   top_irq,
  output logic                   mask_irq,
  output logic [IDX_W-1:0]       win_idx
);
  ctl_t              st;
  logic              in_top, any_q, stk_empty;
  logic [PRIO_W-1:0] win_prio, pop_lvl;
  logic              ack_top, ack_mask, ret_top, ret_mask, push, pop;

  irq_prio_arb #(.NSRC(NSRC), .PW(PRIO_W)) u_arb (
    .valid(req_valid), .prio(req_prio), .lvl(st.lvl),
    .any(any_q), .idx(win_idx), .win_prio(win_prio)
  );

  assign top_irq  = st.pend && !in_top && (st.tmode ? st.gen : nmi_en);
  assign mask_irq = st.gen && any_q && !top_irq && !in_top;

  assign ack_top  = cpu_ack && top_irq;
  assign ack_mask = cpu_ack && mask_irq;
  assign ret_top  = cpu_ret && !cpu_ack && in_top;
  assign ret_mask = cpu_ret && !cpu_ack && !in_top;
  assign push     = ack_mask && st.nest;
  assign pop      = ret_mask && st.nest && !stk_empty;

  irq_lvl_stack #(.DEPTH(STACK_DEPTH), .W(PRIO_W)) u_stk (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .din(st.lvl), .dout(pop_lvl), .empty(stk_empty)
  );

  irq_ctl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
    .trig(top_trig), .ei(cpu_ei), .di(cpu_di),
    .ack_top(ack_top), .ack_mask(ack_mask),
    .ret_top(ret_top), .ret_mask(ret_mask),
    .busy(top_irq || mask_irq), .win_prio(win_prio),
    .pop_ok(pop), .pop_lvl(pop_lvl), .st(st), .in_top(in_top)
  );

  assign reg_rdata = {1'b1, st};
endmodule

// File: rtl/irq_central_chk.sv
module irq_central_chk #(
  parameter int NSRC = 8,
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       reg_rdata,
  input logic             top_trig,
  input logic             reg_wr,
  input logic [NSRC-1:0]  req_valid,
  input logic [NSRC*3-1:0] req_prio,
  input logic             cpu_ack,
  input logic             top_irq,
  input logic             mask_irq,
  input logic [IDX_W-1:0] win_idx
);
  // R1
  bit7_set_chk: assert property (@(posedge clk) disable iff (!rst_n) reg_rdata[7]);
  // R8
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(top_irq && mask_irq));
  // R8
  mask_gen_chk: assert property (@(posedge clk) disable iff (!rst_n) mask_irq |-> reg_rdata[4]);
  // R2
  trig_pend_chk: assert property (@(posedge clk) disable iff (!rst_n) top_trig |=> reg_rdata[6]);
  // R3
  top_mode1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (top_irq && reg_rdata[5]) |-> (reg_rdata[4] && reg_rdata[6]));
  // R4
  ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && mask_irq) |=> !reg_rdata[4]);
  // R6
  conc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && !reg_rdata[3]) |=> (reg_rdata[2:0] == $past(reg_rdata[2:0])));
  // R7
  nest_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && mask_irq && reg_rdata[3]) |=>
    (reg_rdata[2:0] == $past(req_prio[win_idx*3 +: 3])));
  // R9
  win_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_irq |-> (req_valid[win_idx] && (req_prio[win_idx*3 +: 3] < reg_rdata[2:0])));
endmodule

bind irq_central_ctl irq_central_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata), .top_trig(top_trig),
  .reg_wr(reg_wr), .req_valid(req_valid), .req_prio(req_prio),
  .cpu_ack(cpu_ack), .top_irq(top_irq), .mask_irq(mask_irq), .win_idx(win_idx)
);

// File: tb/irq_central_ctl_bench.sv
`timescale 1ns/100ps
module irq_central_ctl_bench;
  localparam int NSRC = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic reg_wr, top_trig, nmi_en, cpu_ei, cpu_di, cpu_ack, cpu_ret;
  logic [7:0] reg_wdata, reg_rdata;
  logic [NSRC-1:0] req_valid;
  logic [NSRC*3-1:0] req_prio;
  logic top_irq, mask_irq;
  logic [2:0] win_idx;

  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_central_ctl u_irq_central_ctl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .top_trig(top_trig), .nmi_en(nmi_en),
    .req_valid(req_valid), .req_prio(req_prio), .cpu_ei(cpu_ei),
    .cpu_di(cpu_di), .cpu_ack(cpu_ack), .cpu_ret(cpu_ret),
    .top_irq(top_irq), .mask_irq(mask_irq), .win_idx(win_idx)
  );

  // reference model state
  logic m_pend, m_tmode, m_gen, m_nest, m_intop, m_defv, m_defval;
  logic [2:0] m_lvl;
  int stk[$];

  function automatic int m_win(output logic found);
    int best = 0, bp = 8;
    found = 0;
    for (int i = 0; i < NSRC; i++) begin
      int p = int'(req_prio[i*3 +: 3]);
      if (req_valid[i] && p < int'(m_lvl) && p < bp) begin
        bp = p; best = i; found = 1;
      end
    end
    return best;
  endfunction

  function automatic logic m_top();
    return m_pend && !m_intop && (m_tmode ? m_gen : nmi_en);
  endfunction

  function automatic logic m_mask();
    logic f;
    int w = m_win(f);
    return m_gen && f && !m_top() && !m_intop && (w >= 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = 0; m_tmode = 0; m_gen = 0; m_nest = 0; m_lvl = 3'd7;
      m_intop = 0; m_defv = 0; m_defval = 0; stk.delete();
    end else begin : upd
      logic t, mk, fnd, at, am, rt, rm, busy, ndefv;
      int w;
      t = m_top(); mk = m_mask(); w = m_win(fnd);
      busy = t || mk;
      at = cpu_ack && t; am = cpu_ack && mk;
      rt = cpu_ret && !cpu_ack && m_intop;
      rm = cpu_ret && !cpu_ack && !m_intop;
      ndefv = 0;
      if (m_defv) m_gen = m_defval;
      if (reg_wr) begin
        m_pend = reg_wdata[6]; m_tmode = reg_wdata[5];
        if (busy) begin ndefv = 1; m_defval = reg_wdata[4]; end
        else m_gen = reg_wdata[4];
      end
      if (rm) begin
        m_gen = 1;
        if (m_nest && stk.size() > 0) begin
          m_lvl = 3'(stk.pop_back());
          if (reg_wr && !m_nest) m_lvl = reg_wdata[2:0];
        end else if (reg_wr) m_lvl = reg_wdata[2:0];
      end else if (am) begin
        if (m_nest) begin
          if (stk.size() < 8) stk.push_back(int'(m_lvl));
          m_lvl = req_prio[w*3 +: 3];
        end else if (reg_wr) m_lvl = reg_wdata[2:0];
      end else if (reg_wr) m_lvl = reg_wdata[2:0];
      if (reg_wr) m_nest = reg_wdata[3];
      if (cpu_ei) m_gen = 1;
      if (cpu_di) m_gen = 0;
      if (am) m_gen = 0;
      if (at) m_pend = 0;
      if (top_trig) m_pend = 1;
      if (rt) m_intop = 0;
      if (at) m_intop = 1;
      m_defv = ndefv;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin : cmp
      logic f;
      int w;
      w = m_win(f);
      chk("R1 R2 R4 R5 R6 R7 register", int'(reg_rdata),
          int'({1'b1, m_pend, m_tmode, m_gen, m_nest, m_lvl}));
      chk("R3 top_irq", int'(top_irq), int'(m_top()));
      chk("R8 mask_irq", int'(mask_irq), int'(m_mask()));
      chk("R9 win_idx", int'(win_idx), f ? w : 0);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
    reg_wr = 0; top_trig = 0; cpu_ei = 0; cpu_di = 0; cpu_ack = 0; cpu_ret = 0;
    #1;
  endtask

  task automatic wr(logic [7:0] v);
    reg_wr = 1; reg_wdata = v; tick();
  endtask

  task automatic setreq(int i, int p);
    req_valid[i] = 1; req_prio[i*3 +: 3] = 3'(p); #0.2;
  endtask

  task automatic clrreq();
    req_valid = '0; #0.2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
      finish_run();
    end
  end

  initial begin
    rst_n = 0; reg_wr = 0; reg_wdata = 0; top_trig = 0; nmi_en = 0;
    cpu_ei = 0; cpu_di = 0; cpu_ack = 0; cpu_ret = 0;
    req_valid = '0; req_prio = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1; #1;
    chk("R1 reset value", int'(reg_rdata), 'h87);
    chk("R3 no top request at reset", int'(top_irq), 0);

    wr(8'h17);
    chk("R1 bit7 forced", int'(reg_rdata), 'h97);

    setreq(3, 2); setreq(5, 2); setreq(1, 4);
    chk("R9 tie to lowest index", int'(win_idx), 3);
    chk("R8 maskable raised", int'(mask_irq), 1);
    cpu_ack = 1; tick();
    chk("R4 R6 concurrent ack", int'(reg_rdata), 'h87);
    cpu_ret = 1; tick();
    chk("R4 return sets enable", int'(reg_rdata), 'h97);
    clrreq();

    wr(8'h12);
    setreq(4, 2);
    chk("R8 priority equal to level", int'(mask_irq), 0);
    setreq(6, 1);
    chk("R9 lower level wins", int'(win_idx), 6);
    clrreq();

    wr(8'h1F);
    setreq(2, 5);
    cpu_ack = 1; tick();
    chk("R7 nested load", int'(reg_rdata), 'h8D);
    setreq(6, 1);
    cpu_ei = 1; tick();
    chk("R9 nested winner", int'(win_idx), 6);
    cpu_ack = 1; tick();
    chk("R7 second nest", int'(reg_rdata), 'h89);
    clrreq();
    cpu_ret = 1; tick();
    chk("R7 pop one", int'(reg_rdata), 'h9D);
    cpu_ret = 1; tick();
    chk("R7 pop two", int'(reg_rdata), 'h9F);

    setreq(0, 3);
    wr(8'h0F);
    chk("R5 enable deferred", int'(reg_rdata), 'h9F);
    tick();
    chk("R5 enable applied", int'(reg_rdata), 'h8F);
    clrreq();

    wr(8'h07);
    nmi_en = 0; top_trig = 1; tick();
    chk("R2 trigger sets pending", int'(reg_rdata), 'hC7);
    chk("R3 mode0 blocked by nmi_en", int'(top_irq), 0);
    nmi_en = 1; #0.2;
    chk("R3 mode0 bypasses enable", int'(top_irq), 1);
    cpu_ack = 1; tick();
    chk("R2 R4 top ack", int'(reg_rdata), 'h87);
    cpu_ret = 1; tick();
    chk("R4 R10 top return keeps enable", int'(reg_rdata), 'h87);
    setreq(0, 3);
    cpu_ei = 1; tick();
    chk("R10 service closed", int'(mask_irq), 1);
    clrreq();

    wr(8'h37);
    nmi_en = 0; top_trig = 1; tick();
    setreq(0, 3);
    chk("R3 mode1 raised", int'(top_irq), 1);
    chk("R8 top precedence", int'(mask_irq), 0);
    cpu_di = 1; tick();
    chk("R3 mode1 needs enable", int'(top_irq), 0);
    cpu_ei = 1; tick();
    cpu_ack = 1; tick();
    chk("R4 top ack keeps enable", int'(reg_rdata), 'hB7);
    chk("R10 no request inside top service", int'(mask_irq), 0);
    cpu_ret = 1; tick();
    chk("R10 return reopens", int'(mask_irq), 1);
    clrreq();

    cpu_ack = 1; tick();
    chk("R10 stray ack ignored", int'(reg_rdata), 'hB7);

    top_trig = 1; tick();
    top_trig = 1; cpu_ack = 1; tick();
    chk("R2 trigger beats ack", int'(reg_rdata), 'hF7);
    wr(8'h37);
    chk("R2 software clear", int'(reg_rdata), 'hB7);
    cpu_ret = 1; tick();
    wr(8'h77);
    chk("R2 software set", int'(top_irq), 1);
    cpu_ack = 1; tick();
    cpu_ret = 1; tick();

    wr(8'h0A);
    cpu_ret = 1; tick();
    chk("R7 empty pop keeps level", int'(reg_rdata), 'h9A);

    for (int n = 0; n < 600; n++) begin
      int r = int'($urandom_range(0, 99));
      reg_wr = (r < 8); reg_wdata = 8'($urandom);
      top_trig = ($urandom_range(0, 15) == 0);
      cpu_ei = ($urandom_range(0, 9) == 0);
      cpu_di = ($urandom_range(0, 19) == 0);
      cpu_ack = ($urandom_range(0, 5) == 0);
      cpu_ret = ($urandom_range(0, 6) == 0);
      if ($urandom_range(0, 3) == 0) begin
        req_valid = NSRC'($urandom); req_prio = (NSRC*3)'($urandom);
      end
      if ($urandom_range(0, 7) == 0) nmi_en = ~nmi_en;
      tick();
    end
    finish_run();
  end
endmodule